// File: doc/BRIEF.md
# Complex-to-Real Quarter-Rate Converter

This block sits at the end of a downconversion chain and, when its enable is high, turns a stream of complex baseband samples into a stream of real samples. Each valid complex sample is rotated by a tone at one quarter of the sample rate. The rotation uses a four-step pattern of swaps and negations, so it needs no multipliers. The real part of the rotated sample then passes through a short symmetric low-pass filter, which removes the unwanted complex image. In real mode only the I output carries data. The Q output is driven to zero and flagged as invalid.

When the enable is low, the block passes the complex pair through unchanged and flags Q as valid. Both modes have the same one-cycle latency, so downstream timing is the same whichever mode is selected. The rotation phase and the filter history restart whenever the enable changes. The first real sample after a mode switch is therefore predictable.

Top module: `c2r_fs4`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by exactly one clock, in both modes.
- R2: With `en_i` low, each valid input appears one clock later with `i_o` = `i_i`, `q_o` = `q_i` and `q_valid_o` high.
- R3: With `en_i` high, each valid input produces `q_o` = 0 and `q_valid_o` low one clock later. `q_valid_o` is never high while `valid_o` is low.
- R4: In real mode, successive valid samples take rotation phases 0, 1, 2, 3, 0, and so on. The rotated real part r is I at phase 0, Q at phase 1, −I at phase 2 and −Q at phase 3. These are the real parts of multiplying by 1, −j, −1 and +j.
- R5: In real mode, `i_o` = floor((r[n] + 2·r[n−1] + r[n−2]) / 4), where r[n−1] and r[n−2] are the rotated values of the two previous valid samples since the last restart, taken as 0 if there are none.
- R6: Reset and any change of `en_i` restart the filter and the phase counter. A valid sample in the cycle where the enable changes uses phase 0 and a zero filter history.
- R7: Negation saturates: −(−2^(DW−1)) gives 2^(DW−1)−1.
- R8: Cycles with `valid_i` low do not advance the phase or the filter, and `i_o` and `q_o` hold their values.
- R9: After reset, all outputs are 0 until the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | 1 = real output, 0 = complex pass-through |
| valid_i | input | 1 | Input sample strobe |
| i_i | input | DW | Input in-phase sample, signed |
| q_i | input | DW | Input quadrature sample, signed |
| valid_o | output | 1 | Output sample strobe |
| i_o | output | DW | Real sample in real mode, otherwise I |
| q_o | output | DW | Q in pass-through mode, 0 in real mode |
| q_valid_o | output | 1 | High with `valid_o` when `q_o` carries data |

## Verification
Constant complex inputs in real mode show the four-step rotation pattern. Each phase selects a different component and sign, so a swap or a sign error at any single phase changes the filtered output. Random streams with idle gaps and mid-stream enable toggles compare the filter taps, the phase advance and the restart rule against a behavioural model, cycle by cycle. Feeding the most negative value at the negating phases separates saturating negation from wrap-around negation. Pass-through bursts confirm that data and the Q flag are unchanged and that the latency matches real mode.

// File: rtl/c2r_pkg.sv
`timescale 1ns/1ps
package c2r_pkg;
  // rotation multiplier per phase: 1, -j, -1, +j
  typedef enum logic [1:0] {
    PH_ONE  = 2'd0,
    PH_NEGJ = 2'd1,
    PH_NEG1 = 2'd2,
    PH_POSJ = 2'd3
  } phase_e;
endpackage

// File: rtl/c2r_phase_ctr.sv
`timescale 1ns/1ps
module c2r_phase_ctr
  import c2r_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   valid_i,
  output phase_e phase_o,
  output logic   restart_o
);
  logic   en_q;
  phase_e ph_q;

  assign restart_o = (en_i != en_q);
  assign phase_o   = restart_o ? PH_ONE : ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      ph_q <= PH_ONE;
    end else begin
      en_q <= en_i;
      if (valid_i && en_i) ph_q <= phase_e'(phase_o + 2'd1);
      else if (restart_o)  ph_q <= PH_ONE;
    end
  end
endmodule

// File: rtl/c2r_rotate.sv
`timescale 1ns/1ps
module c2r_rotate
  import c2r_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] i_i,
  input  logic signed [DW-1:0] q_i,
  input  phase_e               phase_i,
  output logic signed [DW-1:0] re_o
);
  localparam logic signed [DW-1:0] MinVal = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] MaxVal = {1'b0, {(DW-1){1'b1}}};

  function automatic logic signed [DW-1:0] sat_neg(input logic signed [DW-1:0] x);
    return (x == MinVal) ? MaxVal : -x;
  endfunction

  always_comb begin
    unique case (phase_i)
      PH_ONE:  re_o = i_i;
      PH_NEGJ: re_o = q_i;
      PH_NEG1: re_o = sat_neg(i_i);
      default: re_o = sat_neg(q_i);
    endcase
  end
endmodule

// File: rtl/c2r_fir3.sv
`timescale 1ns/1ps
module c2r_fir3 #(
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 restart_i,
  input  logic                 shift_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [DW-1:0] y_o
);
  localparam int AW = DW + 2;

  logic signed [DW-1:0] d1_q, d2_q, d1_u, d2_u;
  logic signed [AW-1:0] acc;

  assign d1_u = restart_i ? '0 : d1_q;
  assign d2_u = restart_i ? '0 : d2_q;

  // taps 1,2,1 with a divide by 4 (floor)
  assign acc = AW'(x_i) + (AW'(d1_u) <<< 1) + AW'(d2_u);
  assign y_o = acc[AW-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d1_q <= '0;
      d2_q <= '0;
    end else if (shift_i) begin
      d1_q <= x_i;
      d2_q <= d1_u;
    end else if (restart_i) begin
      d1_q <= '0;
      d2_q <= '0;
    end
  end
endmodule

// File: rtl/c2r_fs4.sv
`timescale 1ns/1ps
module c2r_fs4
  import c2r_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [DW-1:0] i_i,
  input  logic [DW-1:0] q_i,
  output logic          valid_o,
  output logic [DW-1:0] i_o,
  output logic [DW-1:0] q_o,
  output logic          q_valid_o
);
  phase_e               phase;
  logic                 restart;
  logic signed [DW-1:0] rot_re, fir_y;

  c2r_phase_ctr u_ph (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .valid_i  (valid_i),
    .phase_o  (phase),
    .restart_o(restart)
  );

  c2r_rotate #(.DW(DW)) u_rot (
    .i_i    (i_i),
    .q_i    (q_i),
    .phase_i(phase),
    .re_o   (rot_re)
  );

  c2r_fir3 #(.DW(DW)) u_fir (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .shift_i  (valid_i && en_i),
    .x_i      (rot_re),
    .y_o      (fir_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      q_valid_o <= 1'b0;
      i_o       <= '0;
      q_o       <= '0;
    end else begin
      valid_o   <= valid_i;
      q_valid_o <= valid_i && !en_i;
      if (valid_i) begin
        i_o <= en_i ? fir_y : i_i;
        q_o <= en_i ? '0    : q_i;
      end
    end
  end
endmodule

// File: rtl/c2r_fs4_chk.sv
`timescale 1ns/1ps
module c2r_fs4_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          valid_i,
  input logic [DW-1:0] i_i,
  input logic [DW-1:0] q_i,
  input logic          valid_o,
  input logic [DW-1:0] i_o,
  input logic [DW-1:0] q_o,
  input logic          q_valid_o
);
  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  idle_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R2
  pass_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !en_i) |=> (q_valid_o && i_o == $past(i_i) && q_o == $past(q_i)));
  // R3
  real_q_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && en_i) |=> (!q_valid_o && q_o == '0));
  // R3
  qflag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o |-> valid_o);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(i_o) && $stable(q_o)));
  // R9
  always_comb if (!rst_ni) reset_out_chk: assert (!valid_o && !q_valid_o && i_o == '0 && q_o == '0);
endmodule

bind c2r_fs4 c2r_fs4_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .valid_i  (valid_i),
  .i_i      (i_i),
  .q_i      (q_i),
  .valid_o  (valid_o),
  .i_o      (i_o),
  .q_o      (q_o),
  .q_valid_o(q_valid_o)
);

// File: tb/c2r_fs4_test.sv
`timescale 1ns/1ps
module c2r_fs4_test;
  localparam int DW = 16;
  localparam int MINV = -32768;
  localparam int MAXV = 32767;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, vld = 1'b0;
  logic signed [DW-1:0] ii = '0, qi = '0;
  logic valid_o, q_valid_o;
  logic signed [DW-1:0] i_o, q_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  int m_ph = 0, m_en = 0, m_h1 = 0, m_h2 = 0;
  int e_i = 0, e_q = 0, e_v = 0, e_qv = 0;

  always #2.5 clk = ~clk;

  c2r_fs4 #(.DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .valid_i(vld),
    .i_i(ii), .q_i(qi), .valid_o(valid_o), .i_o(i_o), .q_o(q_o),
    .q_valid_o(q_valid_o)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int neg_sat(int x);
    return (x == MINV) ? MAXV : -x;
  endfunction

  task automatic step(string tag, bit v, bit e, int si, int sq);
    int r;
    @(negedge clk);
    vld = v; en = e; ii = DW'(si); qi = DW'(sq);
    if (int'(e) != m_en) begin m_ph = 0; m_h1 = 0; m_h2 = 0; end
    m_en = e;
    e_v = v; e_qv = v && !e;
    if (v) begin
      if (e) begin
        case (m_ph)
          0: r = si;
          1: r = sq;
          2: r = neg_sat(si);
          default: r = neg_sat(sq);
        endcase
        e_i = (r + 2 * m_h1 + m_h2) >>> 2;
        e_q = 0;
        m_h2 = m_h1; m_h1 = r;
        m_ph = (m_ph + 1) % 4;
      end else begin
        e_i = si; e_q = sq;
      end
    end
    @(posedge clk); #1;
    check(tag, "valid_o", int'(valid_o), e_v);
    check(tag, "q_valid_o", int'(q_valid_o), e_qv);
    check(tag, "i_o", int'(i_o), e_i);
    check(tag, "q_o", int'(q_o), e_q);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    // R9 reset state
    check("R9", "valid_o", int'(valid_o), 0);
    check("R9", "q_valid_o", int'(q_valid_o), 0);
    check("R9", "i_o", int'(i_o), 0);
    check("R9", "q_o", int'(q_o), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 pass-through, R1 latency with gaps
    step("R2", 1, 0, 1234, -567);
    step("R2", 1, 0, MINV, MAXV);
    step("R1", 0, 0, 99, 99);
    step("R2", 1, 0, -1, 7);

    // R4 constant input shows each phase; R6 restart on enable
    step("R6", 1, 1, 400, 800);
    for (int k = 0; k < 7; k++) step("R4", 1, 1, 400, 800);
    step("R3", 1, 1, -1000, 300);

    // R8 gaps do not advance phase or filter
    step("R8", 0, 1, 5555, 5555);
    step("R8", 0, 1, -5555, 1);
    step("R8", 1, 1, 100, 200);
    step("R8", 0, 1, 0, 0);
    step("R8", 1, 1, 100, 200);

    // R7 saturation at phases 2 and 3
    step("R6", 0, 0, 0, 0);
    step("R7", 1, 1, MINV, MINV);
    step("R7", 1, 1, MINV, MINV);
    step("R7", 1, 1, MINV, MINV);
    step("R7", 1, 1, MINV, MINV);
    step("R7", 1, 1, MAXV, MAXV);

    // R6 enable toggles with and without a sample in the change cycle
    step("R6", 1, 0, 10, 20);
    step("R6", 1, 1, 300, -300);
    step("R6", 1, 1, 300, -300);
    step("R6", 0, 0, 1, 1);
    step("R6", 0, 1, 1, 1);
    step("R6", 1, 1, -8, 16);

    // R5 random stream, random gaps and rare mode changes
    for (int k = 0; k < 3000; k++) begin
      bit v, e;
      v = ($urandom % 4) != 0;
      e = (k % 400) < 330;
      step("R5", v, e, int'($signed(16'($urandom))), int'($signed(16'($urandom))));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule